// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block does the stack and vector-table work that a 16-bit processor core performs when it takes an interrupt, and the reverse work when the handler returns. The core hands it requests: a non-maskable strobe, a maskable level with its 8-bit type, a software-interrupt strobe with its type, an instruction-boundary strobe used for single-stepping, and a return strobe. The sequencer picks one request, saves the machine state on the stack through a byte-wide synchronous memory port, and loads the new code pointer from the vector table at address zero. On return it pops the saved state back.

The block owns the FLAGS, CS, IP and SP registers and drives them out. The core can load all four at once while the sequencer is idle. No instruction decode, arithmetic or segment translation takes place here. The stack address is SP itself, and a vector entry is four bytes at type*4. The 16-bit words sit in memory little-endian: low byte at the lower address.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy and mem_we are 0 and FLAGS, CS, IP and SP are all 0.
- R2: When ld_en is high in an idle cycle, the four registers take ld_flags, ld_cs, ld_ip and ld_sp at the next edge. While busy is high, ld_en has no effect.
- R3: Entry writes six bytes in six consecutive cycles, each word low byte first. FLAGS goes to SP-2/SP-1, then CS to SP-4/SP-3, then IP to SP-6/SP-5, where SP is its value at acceptance. SP ends 6 lower.
- R4: The pushed FLAGS word holds the pre-entry value. After entry, FLAGS bit 9 (interrupt enable) and bit 8 (trap) are 0 and the other bits are unchanged.
- R5: After the pushes, the block reads the bytes at type*4 and type*4+1 into IP (low, high) and the bytes at type*4+2 and type*4+3 into CS. mem_rdata returns the byte addressed in the previous cycle.
- R6: On a return strobe, the block reads six bytes starting at SP. It loads IP from SP/SP+1, CS from SP+2/SP+3 and FLAGS from SP+4/SP+5, in that order, makes no writes, and SP ends 6 higher.
- R7: A non-maskable strobe is always accepted, even when FLAGS bit 9 is 0, and it uses vector type 2.
- R8: The maskable level intr_req is accepted with type intr_type only while FLAGS bit 9 is 1. Otherwise it is ignored and the registers do not change.
- R9: An instruction-boundary strobe raises a type 1 entry when FLAGS bit 8 is 1 and has no effect when it is 0.
- R10: The order of preference is: non-maskable, then maskable, then single-step, then software, then return. A strobe that loses is kept pending and is served as soon as the sequencer is idle again.
- R11: busy goes high on the cycle after acceptance. It stays high for 11 cycles on entry (until CS is loaded) and for 7 cycles on return. Strobes that arrive while busy are held and served afterwards.
- R12: A software-interrupt strobe enters through vector sw_type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request strobe |
| intr_req | input | 1 | Maskable request level |
| intr_type | input | 8 | Vector type of the maskable request |
| sw_req | input | 1 | Software interrupt strobe |
| sw_type | input | 8 | Vector type of the software interrupt |
| insn_done | input | 1 | Instruction boundary strobe (single-step source) |
| iret_req | input | 1 | Interrupt return strobe |
| ld_en | input | 1 | Load the four registers (idle only) |
| ld_flags | input | 16 | FLAGS load value |
| ld_cs | input | 16 | CS load value |
| ld_ip | input | 16 | IP load value |
| ld_sp | input | 16 | SP load value |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Read byte, one cycle after its address |
| busy | output | 1 | Sequence in progress |
| flags | output | 16 | FLAGS register |
| cs | output | 16 | CS register |
| ip | output | 16 | IP register |
| sp | output | 16 | SP register |

## Verification
Arbitration and sequencing can fall in the same cycle. A request may arrive while another request is being granted, or while an entry or return is still running. The bench drives the non-maskable strobe in the same cycle as the maskable level, and the step strobe in the same cycle as the maskable level. It also fires a software strobe in the middle of an entry, and keeps the maskable level high across a return that sets the enable bit again. In each case it checks which vector is taken first, that the loser follows exactly one idle cycle later, and that the second stack frame holds the flags already cleared by the first entry.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   // sequencer steps; entry walks PF_LO..VR4, return walks RI_LO..REND
   typedef enum logic [4:0] {
      ST_IDLE,
      ST_PF_LO, ST_PF_HI, ST_PC_LO, ST_PC_HI, ST_PI_LO, ST_PI_HI,
      ST_VR0, ST_VR1, ST_VR2, ST_VR3, ST_VR4,
      ST_RI_LO, ST_RI_HI, ST_RC_LO, ST_RC_HI, ST_RF_LO, ST_RF_HI, ST_REND
   } seq_st_t;

   // request sources, index order is the priority (0 wins)
   localparam int unsigned SRC_NMI  = 0;
   localparam int unsigned SRC_INTR = 1;
   localparam int unsigned SRC_STEP = 2;
   localparam int unsigned SRC_SW   = 3;
   localparam int unsigned SRC_IRET = 4;
   localparam int unsigned SRC_N    = 5;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   // seen[i]: some request with a lower index is active
   logic [N-1:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_pri
      assign grant[i] = req[i] & ~seen[i];
      if (i + 1 < N) begin : g_nx
         assign seen[i+1] = seen[i] | req[i];
      end
   end

endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
   import irq_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  irq_seq_pkg::seq_st_t st,
   input  logic [15:0]          sp,
   input  logic [7:0]           vtype,
   input  logic [15:0]          flags,
   input  logic [15:0]          cs,
   input  logic [15:0]          ip,
   output logic [ADDR_W-1:0]    addr,
   output logic [7:0]           wdata,
   output logic                 we
);

   localparam int unsigned EXT = ADDR_W - 16;

   logic [15:0] a16;
   logic [15:0] vbase;

   assign vbase = {6'b0, vtype, 2'b00};

   always_comb begin
      a16   = '0;
      wdata = '0;
      we    = 1'b0;
      unique case (st)
         ST_PF_LO: begin a16 = sp - 16'd2; wdata = flags[7:0];  we = 1'b1; end
         ST_PF_HI: begin a16 = sp + 16'd1; wdata = flags[15:8]; we = 1'b1; end
         ST_PC_LO: begin a16 = sp - 16'd2; wdata = cs[7:0];     we = 1'b1; end
         ST_PC_HI: begin a16 = sp + 16'd1; wdata = cs[15:8];    we = 1'b1; end
         ST_PI_LO: begin a16 = sp - 16'd2; wdata = ip[7:0];     we = 1'b1; end
         ST_PI_HI: begin a16 = sp + 16'd1; wdata = ip[15:8];    we = 1'b1; end
         ST_VR0:   a16 = vbase;
         ST_VR1:   a16 = vbase + 16'd1;
         ST_VR2:   a16 = vbase + 16'd2;
         ST_VR3:   a16 = vbase + 16'd3;
         ST_RI_LO, ST_RC_LO, ST_RF_LO: a16 = sp;
         ST_RI_HI, ST_RC_HI, ST_RF_HI: a16 = sp + 16'd1;
         default: ;
      endcase
   end

   if (EXT == 0) begin : g_flat
      assign addr = a16;
   end else begin : g_wide
      assign addr = {{EXT{1'b0}}, a16};
   end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IF_BIT    = 9,
   parameter int unsigned TF_BIT    = 8,
   parameter logic [7:0]  NMI_TYPE  = 8'd2,
   parameter logic [7:0]  STEP_TYPE = 8'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic [7:0]        intr_type,
   input  logic              sw_req,
   input  logic [7:0]        sw_type,
   input  logic              insn_done,
   input  logic              iret_req,
   input  logic              ld_en,
   input  logic [15:0]       ld_flags,
   input  logic [15:0]       ld_cs,
   input  logic [15:0]       ld_ip,
   input  logic [15:0]       ld_sp,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic [15:0]       flags,
   output logic [15:0]       cs,
   output logic [15:0]       ip,
   output logic [15:0]       sp
);

   localparam int unsigned WORD_W = 16;

   if (ADDR_W < WORD_W) begin : g_bad_addr
      $error("irq_entry_seq: ADDR_W must cover a 16-bit stack pointer");
   end
   if (IF_BIT >= WORD_W || TF_BIT >= WORD_W || IF_BIT == TF_BIT) begin : g_bad_bits
      $error("irq_entry_seq: flag bit positions out of range");
   end

   seq_st_t          st_q, st_d;
   logic [SRC_N-1:0] pend_q, req, grant, strobe;
   logic [7:0]       vtype_q, swtype_q, sel_type;
   logic [7:0]       byte_q;
   logic             idle, accept;

   assign idle = (st_q == ST_IDLE);
   assign busy = ~idle;

   // strobes that are remembered until served; the maskable level is not
   always_comb begin
      strobe           = '0;
      strobe[SRC_NMI]  = nmi_req;
      strobe[SRC_STEP] = insn_done & flags[TF_BIT];
      strobe[SRC_SW]   = sw_req;
      strobe[SRC_IRET] = iret_req;
      req              = pend_q | strobe;
      req[SRC_INTR]    = intr_req & flags[IF_BIT];
   end

   irq_seq_arb #(.N(SRC_N)) u_arb (
      .req   (req),
      .grant (grant)
   );

   assign accept = idle & (|req);

   always_comb begin
      if (grant[SRC_NMI])       sel_type = NMI_TYPE;
      else if (grant[SRC_INTR]) sel_type = intr_type;
      else if (grant[SRC_STEP]) sel_type = STEP_TYPE;
      else if (sw_req)          sel_type = sw_type;
      else                      sel_type = swtype_q;
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (accept) st_d = grant[SRC_IRET] ? ST_RI_LO : ST_PF_LO;
         ST_PF_LO: st_d = ST_PF_HI;
         ST_PF_HI: st_d = ST_PC_LO;
         ST_PC_LO: st_d = ST_PC_HI;
         ST_PC_HI: st_d = ST_PI_LO;
         ST_PI_LO: st_d = ST_PI_HI;
         ST_PI_HI: st_d = ST_VR0;
         ST_VR0:   st_d = ST_VR1;
         ST_VR1:   st_d = ST_VR2;
         ST_VR2:   st_d = ST_VR3;
         ST_VR3:   st_d = ST_VR4;
         ST_RI_LO: st_d = ST_RI_HI;
         ST_RI_HI: st_d = ST_RC_LO;
         ST_RC_LO: st_d = ST_RC_HI;
         ST_RC_HI: st_d = ST_RF_LO;
         ST_RF_LO: st_d = ST_RF_HI;
         ST_RF_HI: st_d = ST_REND;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         pend_q   <= '0;
         vtype_q  <= '0;
         swtype_q <= '0;
         byte_q   <= '0;
         flags    <= '0;
         cs       <= '0;
         ip       <= '0;
         sp       <= '0;
      end else begin
         st_q   <= st_d;
         pend_q <= (pend_q | strobe) & ~(accept ? grant : '0);
         if (sw_req) swtype_q <= sw_type;
         if (accept) vtype_q <= sel_type;
         if (idle && ld_en) begin
            flags <= ld_flags;
            cs    <= ld_cs;
            ip    <= ld_ip;
            sp    <= ld_sp;
         end
         unique case (st_q)
            ST_PF_LO, ST_PC_LO, ST_PI_LO: sp <= sp - 16'd2;
            ST_PF_HI: begin
               flags[IF_BIT] <= 1'b0;
               flags[TF_BIT] <= 1'b0;
            end
            ST_VR1, ST_VR3: byte_q <= mem_rdata;
            ST_VR2:   ip <= {mem_rdata, byte_q};
            ST_VR4:   cs <= {mem_rdata, byte_q};
            ST_RI_HI, ST_RC_HI, ST_RF_HI: begin
               byte_q <= mem_rdata;
               sp     <= sp + 16'd2;
            end
            ST_RC_LO: ip    <= {mem_rdata, byte_q};
            ST_RF_LO: cs    <= {mem_rdata, byte_q};
            ST_REND:  flags <= {mem_rdata, byte_q};
            default: ;
         endcase
      end
   end

   irq_seq_bus #(.ADDR_W(ADDR_W)) u_bus (
      .st    (st_q),
      .sp    (sp),
      .vtype (vtype_q),
      .flags (flags),
      .cs    (cs),
      .ip    (ip),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .we    (mem_we)
   );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IF_BIT = 9,
   parameter int unsigned TF_BIT = 8,
   parameter int unsigned SRC_N  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [15:0]       sp,
   input logic [15:0]       flags,
   input logic              nmi_req,
   input logic [SRC_N-1:0]  grant
);

   // R1
   we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R3
   byte_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |=> (mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(1))));

   // R3
   sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && (sp != $past(sp))) |->
         ((sp == $past(sp) - 16'd2) || (sp == $past(sp) + 16'd2)));

   // R4
   mask_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_we && $past(mem_we)) |-> (!flags[IF_BIT] && !flags[TF_BIT]));

   // R7
   nmi_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && nmi_req) |=> busy);

   // R10
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
   .ADDR_W (ADDR_W),
   .IF_BIT (IF_BIT),
   .TF_BIT (TF_BIT),
   .SRC_N  (irq_seq_pkg::SRC_N)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .sp       (sp),
   .flags    (flags),
   .nmi_req  (nmi_req),
   .grant    (grant)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

   localparam int unsigned AW = 16;
   localparam logic [15:0] IFM = 16'h0200;
   localparam logic [15:0] TFM = 16'h0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi_req = 1'b0, intr_req = 1'b0, sw_req = 1'b0;
   logic          insn_done = 1'b0, iret_req = 1'b0, ld_en = 1'b0;
   logic [7:0]    intr_type = '0, sw_type = '0;
   logic [15:0]   ld_flags = '0, ld_cs = '0, ld_ip = '0, ld_sp = '0;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          mem_we;
   logic [7:0]    mem_rdata = '0;
   logic          busy;
   logic [15:0]   flags, cs, ip, sp;

   logic [7:0]    mem [0:2047];
   logic [AW-1:0] wa [0:7];
   logic [7:0]    wd [0:7];
   int            wn = 0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [15:0] m_flags, m_cs, m_ip, m_sp;
   logic [15:0] fr_ip [0:15];
   logic [15:0] fr_cs [0:15];
   logic [15:0] fr_fl [0:15];
   int          fdep = 0;

   irq_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .nmi_req(nmi_req), .intr_req(intr_req), .intr_type(intr_type),
      .sw_req(sw_req), .sw_type(sw_type), .insn_done(insn_done), .iret_req(iret_req),
      .ld_en(ld_en), .ld_flags(ld_flags), .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_sp(ld_sp),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
      .busy(busy), .flags(flags), .cs(cs), .ip(ip), .sp(sp)
   );

   always #4ns clk = ~clk;

   // byte memory with one cycle of read latency, plus a write log
   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr[10:0]] <= mem_wdata;
         if (wn < 8) begin
            wa[wn] = mem_addr;
            wd[wn] = mem_wdata;
         end
         wn = wn + 1;
      end
      mem_rdata <= mem[mem_addr[10:0]];
   end

   function automatic logic [15:0] vip(input logic [7:0] t);
      return {t ^ 8'h5A, ~t};
   endfunction

   function automatic logic [15:0] vcs(input logic [7:0] t);
      return {t, t ^ 8'hC3};
   endfunction

   task automatic chkv(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 64) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_load(input logic [15:0] f, input logic [15:0] c,
                          input logic [15:0] i, input logic [15:0] s);
      ld_en = 1'b1; ld_flags = f; ld_cs = c; ld_ip = i; ld_sp = s;
      @(negedge clk);
      ld_en = 1'b0;
      m_flags = f; m_cs = c; m_ip = i; m_sp = s;
   endtask

   task automatic chk_regs(input string rf, input string rc, input string ri, input string rs);
      chkv(rf, flags, m_flags);
      chkv(rc, cs, m_cs);
      chkv(ri, ip, m_ip);
      chkv(rs, sp, m_sp);
   endtask

   // expected effect of one entry through vector t, checked against log and ports
   task automatic exp_entry(input logic [7:0] t);
      logic [15:0] s0;
      logic [15:0] ea [0:5];
      logic [7:0]  ed [0:5];
      s0 = m_sp;
      ea[0] = s0 - 16'd2; ed[0] = m_flags[7:0];
      ea[1] = s0 - 16'd1; ed[1] = m_flags[15:8];
      ea[2] = s0 - 16'd4; ed[2] = m_cs[7:0];
      ea[3] = s0 - 16'd3; ed[3] = m_cs[15:8];
      ea[4] = s0 - 16'd6; ed[4] = m_ip[7:0];
      ea[5] = s0 - 16'd5; ed[5] = m_ip[15:8];
      chkv("R3 write count", wn, 6);
      for (int k = 0; k < 6; k++) begin
         chkv("R3 push addr", wa[k], ea[k]);
         if (k < 2) chkv("R4 pushed flags", wd[k], ed[k]);
         else       chkv("R3 push data", wd[k], ed[k]);
      end
      fr_ip[fdep] = m_ip; fr_cs[fdep] = m_cs; fr_fl[fdep] = m_flags;
      fdep++;
      m_sp    = s0 - 16'd6;
      m_flags = m_flags & ~(IFM | TFM);
      m_ip    = vip(t);
      m_cs    = vcs(t);
      chk_regs("R4 flags", "R5 cs", "R5 ip", "R3 sp");
   endtask

   task automatic exp_iret();
      chkv("R6 no writes", wn, 0);
      fdep--;
      m_ip = fr_ip[fdep]; m_cs = fr_cs[fdep]; m_flags = fr_fl[fdep];
      m_sp = m_sp + 16'd6;
      chk_regs("R6 flags", "R6 cs", "R6 ip", "R6 sp");
   endtask

   task automatic run_sw(input logic [7:0] t);
      int n;
      wn = 0;
      sw_type = t; sw_req = 1'b1;
      @(negedge clk);
      sw_req = 1'b0;
      chkv("R11 busy after accept", busy, 1);
      wait_idle(n);
      chkv("R11 entry length", n, 11);
      exp_entry(t);
   endtask

   task automatic run_iret();
      int n;
      wn = 0;
      iret_req = 1'b1;
      @(negedge clk);
      iret_req = 1'b0;
      wait_idle(n);
      chkv("R11 return length", n, 7);
      exp_iret();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n;
      int unsigned sd;
      logic [7:0] t;
      sd = $urandom(32'd24680);
      for (int v = 0; v < 256; v++) begin
         mem[4*v]     = vip(8'(v)) & 16'h00FF;
         mem[4*v + 1] = 8'(vip(8'(v)) >> 8);
         mem[4*v + 2] = 8'(vcs(8'(v)));
         mem[4*v + 3] = 8'(vcs(8'(v)) >> 8);
      end
      for (int a = 1024; a < 2048; a++) mem[a] = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chkv("R1 busy", busy, 0);
      chkv("R1 we", mem_we, 0);
      m_flags = '0; m_cs = '0; m_ip = '0; m_sp = '0;
      chk_regs("R1 flags", "R1 cs", "R1 ip", "R1 sp");

      // R2
      do_load(16'h00C5, 16'h1234, 16'h5678, 16'h0700);
      chk_regs("R2 flags", "R2 cs", "R2 ip", "R2 sp");

      // R12 with a load attempted mid-entry (R2 ignored while busy)
      wn = 0;
      sw_type = 8'h21; sw_req = 1'b1;
      @(negedge clk);
      sw_req = 1'b0;
      ld_en = 1'b1; ld_flags = 16'hFFFF; ld_cs = 16'hAAAA; ld_ip = 16'hBBBB; ld_sp = 16'h0600;
      @(negedge clk);
      ld_en = 1'b0;
      wait_idle(n);
      chkv("R11 entry length", n, 10);
      exp_entry(8'h21);
      run_iret();

      // R8 masked: IF is 0
      intr_type = 8'h30; intr_req = 1'b1;
      repeat (4) @(negedge clk);
      chkv("R8 masked busy", busy, 0);
      chk_regs("R8 flags", "R8 cs", "R8 ip", "R8 sp");
      intr_req = 1'b0;

      // R9 step with TF clear has no effect
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = 1'b0;
      @(negedge clk);
      chkv("R9 no step busy", busy, 0);
      chk_regs("R9 flags", "R9 cs", "R9 ip", "R9 sp");

      // R8 accepted with IF set
      do_load(IFM | 16'h0001, 16'h2000, 16'h0100, 16'h0780);
      wn = 0;
      intr_type = 8'h30; intr_req = 1'b1;
      @(negedge clk);
      intr_req = 1'b0;
      chkv("R8 accepted", busy, 1);
      wait_idle(n);
      exp_entry(8'h30);
      run_iret();

      // R7 NMI with IF clear
      do_load(16'h0040, 16'h3000, 16'h0200, 16'h0760);
      wn = 0;
      nmi_req = 1'b1;
      @(negedge clk);
      nmi_req = 1'b0;
      chkv("R7 nmi accepted", busy, 1);
      wait_idle(n);
      exp_entry(8'd2);
      run_iret();

      // R9 single step with TF set, then restored by return
      do_load(TFM | 16'h0004, 16'h4000, 16'h0300, 16'h0740);
      wn = 0;
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = 1'b0;
      chkv("R9 step accepted", busy, 1);
      wait_idle(n);
      exp_entry(8'd1);
      chkv("R9 TF cleared", flags & TFM, 0);
      run_iret();
      chkv("R9 TF restored", flags & TFM, TFM);

      // R10 NMI and INTR in the same cycle; INTR returns after return sets IF
      do_load(IFM, 16'h5000, 16'h0400, 16'h0720);
      wn = 0;
      intr_type = 8'h44; intr_req = 1'b1; nmi_req = 1'b1;
      @(negedge clk);
      nmi_req = 1'b0;
      wait_idle(n);
      exp_entry(8'd2);
      chkv("R10 intr held off by IF", busy, 0);
      run_iret();
      wn = 0;
      @(negedge clk);
      chkv("R10 intr after return", busy, 1);
      intr_req = 1'b0;
      wait_idle(n);
      exp_entry(8'h44);
      run_iret();

      // R10 INTR over single step; step follows one idle cycle later
      do_load(IFM | TFM, 16'h6000, 16'h0500, 16'h0700);
      wn = 0;
      intr_type = 8'h55; intr_req = 1'b1; insn_done = 1'b1;
      @(negedge clk);
      intr_req = 1'b0; insn_done = 1'b0;
      wait_idle(n);
      exp_entry(8'h55);
      chkv("R10 gap idle", busy, 0);
      wn = 0;
      @(negedge clk);
      chkv("R10 step pending served", busy, 1);
      wait_idle(n);
      exp_entry(8'd1);
      run_iret();
      run_iret();

      // R11 software strobe during an NMI entry is held
      do_load(16'h0000, 16'h7000, 16'h0600, 16'h06F0);
      wn = 0;
      nmi_req = 1'b1;
      @(negedge clk);
      nmi_req = 1'b0;
      repeat (3) @(negedge clk);
      sw_type = 8'h66; sw_req = 1'b1;
      @(negedge clk);
      sw_req = 1'b0;
      wait_idle(n);
      exp_entry(8'd2);
      wn = 0;
      @(negedge clk);
      chkv("R11 held sw served", busy, 1);
      wait_idle(n);
      exp_entry(8'h66);
      run_iret();
      run_iret();

      // R12 random software vectors and frames
      for (int it = 0; it < 40; it++) begin
         t = 8'($urandom);
         do_load(16'($urandom) & ~(IFM | TFM), 16'($urandom), 16'($urandom),
                 16'(16'h0500 + 2 * $urandom_range(0, 300)));
         run_sw(t);
         run_iret();
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule